// File: doc/BRIEF.md
# BCD Calendar Clock Register File

This block keeps time of day and the calendar in a chain of packed-BCD counters that advance on a one-per-second strobe. A host sees the clock as eight byte locations at the very top of a 32K x 8 address space. Those locations are holding registers, not the counters. On every accepted tick the holding registers take the new count together in one edge.

Two control bits in the lowest location change how the holding registers behave. One freezes them so that the host can read a stable snapshot while the counters keep running. The other freezes them and lets the host load new values. When the host clears that second bit, all the time fields are copied into the counters at once.

Other control bits live in the time locations themselves. One stops the count. Another enables a century flag that toggles when the year wraps. A third puts a test square wave on the lowest data bit of the seconds location. Ticks and host accesses share one synchronous clock. Reads are combinational, and writes take effect at the clock edge on which they are presented.

Top module: `cal_clock_regs`

## Requirements
- R1: The clock window is the eight addresses whose upper 12 bits are all ones (7FF8h to 7FFFh). Offsets 0 to 7 hold control, seconds, minutes, hours, century/day, date, month and year. After reset these read 00, 80, 00, 00, 01, 01, 01 and 00. Reads outside the window return 00, and writes outside the window change nothing.
- R2: Seconds and minutes count in BCD from 00 to 59, and hours from 00 to 23. Each one wraps to 00 and carries into the next field.
- R3: At midnight the date advances. It returns to 01 after the last day of the month: 28 or 29 in February, 30 in April, June, September and November, and 31 otherwise. A year is a leap year when its value is divisible by 4. The day of week (century/day bits 2:0) counts 1 to 7 and then returns to 1.
- R4: The month wraps from 12 to 01 and increments the year. The year wraps from 99 to 00.
- R5: Century/day bit 5 is the century enable and bit 4 is the century flag. When the enable is 1, the flag inverts on a year wrap from 99 to 00; when it is 0, the flag holds. The enable can be written at any time.
- R6: Seconds bit 7 is the stop bit and is 1 after reset. While it is 1, ticks are ignored. It can be written at any time, and once it is cleared the next tick advances the count.
- R7: Control bit 6 is the read-hold bit. While it is 1, the holding registers keep their contents and the counters go on counting. The first tick after the bit is cleared shows the current count.
- R8: Control bit 7 is the load bit. The time digits, the century flag and the day of week accept host writes only while this bit is 1. At other times, writes to those fields are ignored.
- R9: Writing the control location with bit 7 at 0 while it was 1 copies every holding time field into the counters on that edge. A tick presented on the same edge is dropped.
- R10: A tick presented on the same edge as a write that sets a hold bit still refreshes the holding registers.
- R11: Reserved bits read as 0 whatever was written: seconds has none, minutes bit 7, hours bits 7:6, century/day bits 7 and 3, date bits 7:6, month bits 7:5.
- R12: Century/day bit 6 is the test bit. While it is 1 and the stop bit is 0, bit 0 of the seconds read data is the square-wave input. At all other times, bit 0 is the seconds digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the counters and the host port |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-per-second advance strobe, one cycle wide |
| ftest_i | input | 1 | Square wave shown on seconds bit 0 in test mode |
| sel_i | input | 1 | Host access strobe |
| we_i | input | 1 | Host write when high, read when low |
| addr_i | input | 15 (ADDR_W) | Host byte address |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data, combinational |

## Verification
Read data is combinational from the address, so a read is due in the same cycle as its address. The bench therefore samples it one time step after it drives the address on the falling edge. Writes and ticks take effect on the rising edge that follows the falling edge where they are driven. Each result is read back on the next falling edge, with no extra cycle of latency assumed anywhere. Two same-edge cases are checked at their exact edge by driving the tick together with the control write: the refresh that still lands when a hold is set, and the tick that is dropped when a load happens.

// File: rtl/cal_pkg.sv
package cal_pkg;

  typedef enum logic [2:0] {
    LOC_CTRL = 3'd0, LOC_SEC = 3'd1, LOC_MIN = 3'd2, LOC_HOUR = 3'd3,
    LOC_CDAY = 3'd4, LOC_DATE = 3'd5, LOC_MON = 3'd6, LOC_YEAR = 3'd7
  } loc_e;

  typedef struct packed {
    logic       cb;
    logic [7:0] year;
    logic [4:0] mon;
    logic [5:0] date;
    logic [2:0] day;
    logic [5:0] hour;
    logic [6:0] min;
    logic [6:0] sec;
  } tod_t;

  localparam tod_t TOD_RST = '{cb: 1'b0, year: 8'h00, mon: 5'h01, date: 6'h01,
                               day: 3'd1, hour: 6'h00, min: 7'h00, sec: 7'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) bcd_inc = {v[7:4] + 4'd1, 4'd0};
    else                bcd_inc = {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [5:0] month_last(input logic [4:0] mon, input logic [7:0] yr);
    logic [6:0] bin;
    bin = 7'(yr[7:4]) * 7'd10 + 7'(yr[3:0]);
    case (mon)
      5'h02:                      month_last = (bin[1:0] == 2'd0) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: month_last = 6'h30;
      default:                    month_last = 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/cal_chain.sv
module cal_chain
  import cal_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic load_i,
  input  logic ceb_i,
  input  tod_t load_val_i,
  output tod_t cnt_o,
  output tod_t nxt_o
);

  tod_t cnt_q, nxt;
  logic c_min, c_hour, c_day, c_mon, c_year;

  always_comb begin
    nxt    = cnt_q;
    c_min  = cnt_q.sec == 7'h59;
    c_hour = c_min && (cnt_q.min == 7'h59);
    c_day  = c_hour && (cnt_q.hour == 6'h23);
    c_mon  = c_day && (cnt_q.date >= month_last(cnt_q.mon, cnt_q.year));
    c_year = c_mon && (cnt_q.mon == 5'h12);
    nxt.sec = c_min ? 7'h00 : 7'(bcd_inc({1'b0, cnt_q.sec}));
    if (c_min)  nxt.min  = c_hour ? 7'h00 : 7'(bcd_inc({1'b0, cnt_q.min}));
    if (c_hour) nxt.hour = c_day ? 6'h00 : 6'(bcd_inc({2'b0, cnt_q.hour}));
    if (c_day) begin
      nxt.day  = (cnt_q.day >= 3'd7) ? 3'd1 : cnt_q.day + 3'd1;
      nxt.date = c_mon ? 6'h01 : 6'(bcd_inc({2'b0, cnt_q.date}));
    end
    if (c_mon) nxt.mon = c_year ? 5'h01 : 5'(bcd_inc({3'b0, cnt_q.mon}));
    if (c_year) begin
      nxt.year = (cnt_q.year == 8'h99) ? 8'h00 : bcd_inc(cnt_q.year);
      if (cnt_q.year == 8'h99 && ceb_i) nxt.cb = ~cnt_q.cb;
    end
  end

  // transfer outranks a same-edge tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= TOD_RST;
    else if (load_i) cnt_q <= load_val_i;
    else if (adv_i)  cnt_q <= nxt;
  end

  assign cnt_o = cnt_q;
  assign nxt_o = nxt;

  assert_idle_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !load_i) |=> $stable(cnt_q));
  assert_transfer_all_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)));
  assert_sec_moves_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i) |=> (cnt_q.sec != $past(cnt_q.sec)));

endmodule

// File: rtl/cal_host.sv
module cal_host
  import cal_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              tick_i,
  input  logic              ftest_i,
  input  tod_t              nxt_i,
  output logic              adv_o,
  output logic              load_o,
  output logic              ceb_o,
  output tod_t              load_val_o
);

  localparam int HI_W = ADDR_W - 3;

  logic       wbit_q, rbit_q, stop_q, ft_q, ceb_q;
  logic [5:0] cal_q;
  tod_t       hold_q;
  logic       in_win, wr, halt, time_wr;
  loc_e       loc;
  logic [7:0] rd;

  assign in_win  = addr_i[ADDR_W-1:3] == {HI_W{1'b1}};
  assign loc     = loc_e'(addr_i[2:0]);
  assign wr      = sel_i && we_i && in_win;
  assign halt    = wbit_q || rbit_q;
  assign adv_o   = tick_i && !stop_q;
  assign load_o  = wr && (loc == LOC_CTRL) && wbit_q && !wdata_i[7];
  assign time_wr = wr && wbit_q && (loc != LOC_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {wbit_q, rbit_q, cal_q} <= '0;
      stop_q <= 1'b1;
      ft_q   <= 1'b0;
      ceb_q  <= 1'b0;
      hold_q <= TOD_RST;
    end else begin
      // halt sampled before the edge: a refresh already due still lands
      if (adv_o && !halt) hold_q <= nxt_i;
      if (wr) begin
        case (loc)
          LOC_CTRL: {wbit_q, rbit_q, cal_q} <= wdata_i;
          LOC_SEC: begin
            stop_q <= wdata_i[7];
            if (wbit_q) hold_q.sec <= wdata_i[6:0];
          end
          LOC_MIN:  if (wbit_q) hold_q.min  <= wdata_i[6:0];
          LOC_HOUR: if (wbit_q) hold_q.hour <= wdata_i[5:0];
          LOC_CDAY: begin
            ft_q  <= wdata_i[6];
            ceb_q <= wdata_i[5];
            if (wbit_q) begin
              hold_q.cb  <= wdata_i[4];
              hold_q.day <= wdata_i[2:0];
            end
          end
          LOC_DATE: if (wbit_q) hold_q.date <= wdata_i[5:0];
          LOC_MON:  if (wbit_q) hold_q.mon  <= wdata_i[4:0];
          LOC_YEAR: if (wbit_q) hold_q.year <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (loc)
      LOC_CTRL: rd = {wbit_q, rbit_q, cal_q};
      LOC_SEC:  rd = {stop_q, hold_q.sec[6:1], (ft_q && !stop_q) ? ftest_i : hold_q.sec[0]};
      LOC_MIN:  rd = {1'b0, hold_q.min};
      LOC_HOUR: rd = {2'b0, hold_q.hour};
      LOC_CDAY: rd = {1'b0, ft_q, ceb_q, hold_q.cb, 1'b0, hold_q.day};
      LOC_DATE: rd = {2'b0, hold_q.date};
      LOC_MON:  rd = {3'b0, hold_q.mon};
      default:  rd = hold_q.year;
    endcase
  end

  assign rdata_o    = (sel_i && in_win) ? rd : 8'h00;
  assign ceb_o      = ceb_q;
  assign load_val_o = hold_q;

  assert_hold_frozen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt && !time_wr) |=> $stable(hold_q));
  assert_mon_rsvd_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && in_win && loc == LOC_MON) |-> (rdata_o[7:5] == 3'b000));

endmodule

// File: rtl/cal_clock_regs.sv
module cal_clock_regs
  import cal_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              ftest_i,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);

  tod_t cnt, nxt, load_val;
  logic adv, load, ceb;

  cal_host #(.ADDR_W(ADDR_W)) i_host (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .tick_i(tick_i), .ftest_i(ftest_i),
    .nxt_i(nxt), .adv_o(adv), .load_o(load), .ceb_o(ceb), .load_val_o(load_val)
  );

  cal_chain i_chain (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(adv), .load_i(load), .ceb_i(ceb),
    .load_val_i(load_val), .cnt_o(cnt), .nxt_o(nxt)
  );

  assert_load_not_stale_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (cnt.sec == $past(load_val.sec)));

endmodule

// File: tb/test_cal_clock_regs.sv
module test_cal_clock_regs;

  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, ftest = 1'b0, sel = 1'b0, we = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  int checks = 0, errors = 0;

  localparam logic [14:0] BASE = 15'h7FF8;

  always #10 clk = ~clk;

  cal_clock_regs i_cal_clock_regs (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .ftest_i(ftest), .sel_i(sel),
    .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) % 10) * 16 + v % 10);
  endfunction

  function automatic int days_in(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr_a(input logic [14:0] a, input logic [7:0] d, input logic with_tick);
    @(negedge clk); sel = 1'b1; we = 1'b1; addr = a; wdata = d; tick = with_tick;
    @(negedge clk); sel = 1'b0; we = 1'b0; tick = 1'b0;
  endtask

  task automatic wr(input int loc, input logic [7:0] d);
    wr_a(BASE + 15'(loc), d, 1'b0);
  endtask

  task automatic rd_a(input logic [14:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic expect_loc(input string tag, input int loc, input logic [7:0] exp);
    logic [7:0] d;
    rd_a(BASE + 15'(loc), d);
    chk(tag, d, exp);
  endtask

  task automatic do_tick(input int n);
    repeat (n) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic set_time(input int y, input int m, input int d, input int h, input int mi,
                          input int s, input int dow, input logic ceb, input logic cb);
    wr(0, 8'h80);
    wr(1, bcd(s)); wr(2, bcd(mi)); wr(3, bcd(h));
    wr(4, {2'b00, ceb, cb, 1'b0, 3'(dow)});
    wr(5, bcd(d)); wr(6, bcd(m)); wr(7, bcd(y));
    wr(0, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog got timeout exp done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int yrs[4] = '{23, 24, 0, 99};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset image and window decode
    expect_loc("R1 ctrl", 0, 8'h00); expect_loc("R1 sec", 1, 8'h80);
    expect_loc("R1 min", 2, 8'h00);  expect_loc("R1 hour", 3, 8'h00);
    expect_loc("R1 cday", 4, 8'h01); expect_loc("R1 date", 5, 8'h01);
    expect_loc("R1 mon", 6, 8'h01);  expect_loc("R1 year", 7, 8'h00);
    rd_a(15'h0123, d); chk("R1 outside read", d, 8'h00);
    wr_a(15'h7FF0, 8'hFF, 1'b0);
    expect_loc("R1 outside write", 0, 8'h00);

    // R6 stop bit
    do_tick(3);
    expect_loc("R6 stopped", 1, 8'h80);
    wr(1, 8'h00);
    expect_loc("R6 cleared", 1, 8'h00);
    do_tick(1);
    expect_loc("R6 resumes", 1, 8'h01);

    // R8 time writes ignored without load bit
    wr(2, 8'h33); wr(3, 8'h12);
    expect_loc("R8 min ignored", 2, 8'h00);
    expect_loc("R8 hour ignored", 3, 8'h00);

    // R2 sweep across midnight
    set_time(24, 2, 28, 23, 59, 0, 3, 1'b0, 1'b0);
    for (int k = 1; k <= 61; k++) begin
      int t;
      do_tick(1);
      t = (23 * 3600 + 59 * 60 + k) % 86400;
      expect_loc("R2 sec", 1, bcd(t % 60));
      expect_loc("R2 min", 2, bcd((t / 60) % 60));
      expect_loc("R2 hour", 3, bcd(t / 3600));
    end
    expect_loc("R3 leap feb 29", 5, 8'h29);
    expect_loc("R3 dow 3 to 4", 4, 8'h04);

    // R3 R4 month length and rollover sweep
    foreach (yrs[i]) begin
      for (int m = 1; m <= 12; m++) begin
        int len;
        len = days_in(m, yrs[i]);
        set_time(yrs[i], m, len - 1, 23, 59, 59, 7, 1'b0, 1'b0);
        do_tick(1);
        expect_loc("R3 last date", 5, bcd(len));
        expect_loc("R3 dow wrap", 4, 8'h01);
        expect_loc("R3 same month", 6, bcd(m));
        set_time(yrs[i], m, len, 23, 59, 59, 2, 1'b0, 1'b0);
        do_tick(1);
        expect_loc("R3 date wrap", 5, 8'h01);
        expect_loc("R4 month", 6, bcd(m % 12 + 1));
        expect_loc("R4 year", 7, bcd(m == 12 ? (yrs[i] + 1) % 100 : yrs[i]));
        expect_loc("R2 hour wrap", 3, 8'h00);
      end
    end

    // R5 century flag
    set_time(99, 12, 31, 23, 59, 59, 5, 1'b1, 1'b0);
    do_tick(1);
    expect_loc("R5 cb set", 4, 8'h36);
    expect_loc("R4 year wrap", 7, 8'h00);
    set_time(99, 12, 31, 23, 59, 59, 5, 1'b1, 1'b1);
    do_tick(1);
    expect_loc("R5 cb clear", 4, 8'h26);
    set_time(99, 12, 31, 23, 59, 59, 5, 1'b0, 1'b1);
    do_tick(1);
    expect_loc("R5 cb hold", 4, 8'h16);
    wr(4, 8'h20);
    expect_loc("R5 ceb free write", 4, 8'h36);
    wr(4, 8'h00);
    expect_loc("R5 ceb clear", 4, 8'h16);

    // R7 read hold
    set_time(24, 1, 1, 0, 0, 0, 1, 1'b0, 1'b0);
    wr(0, 8'h40);
    do_tick(5);
    expect_loc("R7 frozen", 1, 8'h00);
    expect_loc("R7 ctrl", 0, 8'h40);
    wr(0, 8'h00);
    expect_loc("R7 no tick yet", 1, 8'h00);
    do_tick(1);
    expect_loc("R7 caught up", 1, 8'h06);

    // R10 hold set on a tick edge
    wr_a(BASE, 8'h40, 1'b1);
    expect_loc("R10 refresh kept", 1, 8'h07);
    do_tick(1);
    expect_loc("R10 then frozen", 1, 8'h07);
    wr(0, 8'h00);
    do_tick(1);
    expect_loc("R10 resumed", 1, 8'h09);

    // R9 transfer on load-bit release
    wr(0, 8'h80);
    do_tick(2);
    expect_loc("R9 frozen under load", 1, 8'h09);
    wr(1, 8'h30); wr(2, 8'h45); wr(3, 8'h12);
    expect_loc("R8 accepted", 1, 8'h30);
    do_tick(1);
    wr_a(BASE, 8'h00, 1'b1);
    expect_loc("R9 sec", 1, 8'h30);
    expect_loc("R9 min", 2, 8'h45);
    expect_loc("R9 hour", 3, 8'h12);
    do_tick(1);
    expect_loc("R9 counts from load", 1, 8'h31);
    expect_loc("R9 min kept", 2, 8'h45);

    // R11 reserved bits
    wr(0, 8'h80);
    wr(6, 8'hFF); expect_loc("R11 month", 6, 8'h1F);
    wr(3, 8'hFF); expect_loc("R11 hour", 3, 8'h3F);
    wr(5, 8'hFF); expect_loc("R11 date", 5, 8'h3F);
    wr(2, 8'hFF); expect_loc("R11 min", 2, 8'h7F);
    wr(4, 8'hFF); expect_loc("R11 cday", 4, 8'h77);

    // R12 test square wave
    set_time(24, 3, 1, 0, 0, 10, 5, 1'b0, 1'b0);
    wr(4, 8'h45);
    ftest = 1'b1;
    expect_loc("R12 wave high", 1, 8'h11);
    ftest = 1'b0;
    expect_loc("R12 wave low", 1, 8'h10);
    wr(1, 8'h80);
    ftest = 1'b1;
    expect_loc("R12 off when stopped", 1, 8'h90);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule